// File: doc/BRIEF.md
# Shared Cache Request Priority Arbiter

This block chooses one winner per cycle among five request sources that compete for a shared second-level cache. The sources are bus snoops, first-level data reloads, first-level data castouts, instruction fetches and second-level instruction reloads. Each source drives a valid bit and a byte address. The arbiter answers with a one-hot grant vector and passes on the winner's address in the same cycle.

The ranking is fixed, with two exceptions. A castout normally waits behind a data reload. When both target the same cache block, the castout goes first, so that a write and a later read of one block reach the cache in program order. The two instruction sources share the bottom rank and take turns, so neither of them starves.

Top module: `l2arb_top`

## Requirements
- R1: Grant bit 0 (snoop) is asserted in every cycle in which the snoop source is valid, whatever else is pending.
- R2: Grant bit 1 (data reload) wins when the snoop source is idle, unless a valid castout targets the same block. A castout that is not valid never blocks the reload, whatever its address.
- R3: When both the reload and the castout are valid, the snoop is idle, and their addresses agree in bits [31:5], grant bit 2 (castout) wins. Address bits [4:0] take no part in this comparison.
- R4: When the castout targets a different block, it ranks below the data reload and above both instruction sources.
- R5: Grant bit 3 (instruction fetch) and grant bit 4 (instruction reload) are given only when the snoop, reload and castout sources are all idle.
- R6: When both instruction sources are valid and no higher source is valid, the grant alternates between them. The first such contest after reset goes to instruction fetch. The turn changes only in a cycle in which one of the two instruction sources is granted.
- R7: At most one grant bit is high. Exactly one is high in any cycle with a valid source, and none in an idle cycle. The grant follows the current valid inputs combinationally, in the same cycle.
- R8: `grantAddr` equals the address of the granted source, and is zero when no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snoopValid | input | 1 | Snoop request pending |
| snoopAddr | input | ADDR_W | Snoop address |
| dReloadValid | input | 1 | First-level data reload pending |
| dReloadAddr | input | ADDR_W | Data reload address |
| castoutValid | input | 1 | First-level data castout pending |
| castoutAddr | input | ADDR_W | Castout address |
| iFetchValid | input | 1 | Instruction fetch pending |
| iFetchAddr | input | ADDR_W | Instruction fetch address |
| iReloadValid | input | 1 | Second-level instruction reload pending |
| iReloadAddr | input | ADDR_W | Instruction reload address |
| grant | output | 5 | One-hot grant: bit0 snoop, bit1 reload, bit2 castout, bit3 fetch, bit4 instruction reload |
| grantAddr | output | ADDR_W | Address of the granted source |

## Verification
The assertions assume that the valid inputs are stable and known for the whole cycle after the falling edge. The alternation property also assumes that a contest between the two instruction sources can run over back-to-back cycles. The bench changes every input only at the falling edge. It holds the same pattern across consecutive cycles to exercise the turn-taking. Its random phase draws addresses from a few nearby lines, with varying offsets, so that same-block and different-block pairs both occur often.

// File: rtl/l2arb_pkg.sv
package l2arb_pkg;
  localparam int NUM_SRC = 5;
  localparam int SRC_SNOOP = 0;
  localparam int SRC_DRELOAD = 1;
  localparam int SRC_CASTOUT = 2;
  localparam int SRC_IFETCH = 3;
  localparam int SRC_IRELOAD = 4;

  typedef struct packed {
    logic fetchWon;
    logic iReloadWon;
  } lowStrobe_t;
endpackage

// File: rtl/l2arb_datapath.sv
module l2arb_datapath
  import l2arb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0]    srcAddr,
  input  logic [NUM_SRC-1:0]                grant,
  input  lowStrobe_t                        strobe,
  output logic                              blockMatch,
  output logic                              favorReload,
  output logic [ADDR_W-1:0]                 grantAddr
);
  localparam int OFFSET_W = $clog2(LINE_BYTES);

  // Line-granular compare between data reload and castout
  assign blockMatch = (srcAddr[SRC_DRELOAD][ADDR_W-1:OFFSET_W] ==
                       srcAddr[SRC_CASTOUT][ADDR_W-1:OFFSET_W]);

  // Turn pointer for the two instruction sources
  always_ff @(posedge clk) begin
    if (!rstN) begin
      favorReload <= 1'b0;
    end else if (strobe.fetchWon) begin
      favorReload <= 1'b1;
    end else if (strobe.iReloadWon) begin
      favorReload <= 1'b0;
    end
  end

  // AND-OR address mux steered by the one-hot grant
  logic [NUM_SRC-1:0][ADDR_W-1:0] maskedAddr;
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_mask
    assign maskedAddr[s] = srcAddr[s] & {ADDR_W{grant[s]}};
  end

  always_comb begin
    grantAddr = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      grantAddr = grantAddr | maskedAddr[s];
    end
  end
endmodule

// File: rtl/l2arb_control.sv
module l2arb_control
  import l2arb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] valid,
  input  logic               blockMatch,
  input  logic               favorReload,
  output logic [NUM_SRC-1:0] grant,
  output lowStrobe_t         strobe
);
  logic highIdle;
  logic lowContest;

  assign highIdle = !valid[SRC_SNOOP] && !valid[SRC_DRELOAD] && !valid[SRC_CASTOUT];
  assign lowContest = highIdle && valid[SRC_IFETCH] && valid[SRC_IRELOAD];

  always_comb begin
    grant = '0;
    if (valid[SRC_SNOOP]) begin
      grant[SRC_SNOOP] = 1'b1;
    end else if (valid[SRC_DRELOAD] && valid[SRC_CASTOUT] && blockMatch) begin
      grant[SRC_CASTOUT] = 1'b1;
    end else if (valid[SRC_DRELOAD]) begin
      grant[SRC_DRELOAD] = 1'b1;
    end else if (valid[SRC_CASTOUT]) begin
      grant[SRC_CASTOUT] = 1'b1;
    end else if (lowContest) begin
      if (favorReload) grant[SRC_IRELOAD] = 1'b1;
      else             grant[SRC_IFETCH] = 1'b1;
    end else if (valid[SRC_IFETCH]) begin
      grant[SRC_IFETCH] = 1'b1;
    end else if (valid[SRC_IRELOAD]) begin
      grant[SRC_IRELOAD] = 1'b1;
    end
  end

  assign strobe.fetchWon = grant[SRC_IFETCH];
  assign strobe.iReloadWon = grant[SRC_IRELOAD];

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R7
  AST_GRANT_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (|valid) |-> (|grant)); // R7
  AST_GRANT_ONLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~valid) == '0); // R7
  AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    valid[SRC_SNOOP] |-> grant[SRC_SNOOP]); // R1
  AST_RELOAD_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (valid[SRC_DRELOAD] && !valid[SRC_SNOOP] && !(valid[SRC_CASTOUT] && blockMatch))
      |-> grant[SRC_DRELOAD]); // R2
  AST_CASTOUT_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (valid[SRC_DRELOAD] && valid[SRC_CASTOUT] && !valid[SRC_SNOOP] && blockMatch)
      |-> grant[SRC_CASTOUT]); // R3
  AST_LOW_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (grant[SRC_IFETCH] || grant[SRC_IRELOAD]) |-> highIdle); // R5
  AST_LOW_ALTERNATE: assert property (@(posedge clk) disable iff (!rstN)
    (lowContest && $past(rstN) && $past(lowContest) && $past(grant[SRC_IFETCH]))
      |-> grant[SRC_IRELOAD]); // R6
endmodule

// File: rtl/l2arb_top.sv
module l2arb_top
  import l2arb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               snoopValid,
  input  logic [ADDR_W-1:0]  snoopAddr,
  input  logic               dReloadValid,
  input  logic [ADDR_W-1:0]  dReloadAddr,
  input  logic               castoutValid,
  input  logic [ADDR_W-1:0]  castoutAddr,
  input  logic               iFetchValid,
  input  logic [ADDR_W-1:0]  iFetchAddr,
  input  logic               iReloadValid,
  input  logic [ADDR_W-1:0]  iReloadAddr,
  output logic [4:0]         grant,
  output logic [ADDR_W-1:0]  grantAddr
);
  logic [NUM_SRC-1:0]             valid;
  logic [NUM_SRC-1:0][ADDR_W-1:0] srcAddr;
  logic                           blockMatch;
  logic                           favorReload;
  lowStrobe_t                     strobe;

  assign valid = {iReloadValid, iFetchValid, castoutValid, dReloadValid, snoopValid};
  assign srcAddr[SRC_SNOOP] = snoopAddr;
  assign srcAddr[SRC_DRELOAD] = dReloadAddr;
  assign srcAddr[SRC_CASTOUT] = castoutAddr;
  assign srcAddr[SRC_IFETCH] = iFetchAddr;
  assign srcAddr[SRC_IRELOAD] = iReloadAddr;

  l2arb_control u_control (
    .clk(clk), .rstN(rstN), .valid(valid), .blockMatch(blockMatch),
    .favorReload(favorReload), .grant(grant), .strobe(strobe)
  );

  l2arb_datapath #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_datapath (
    .clk(clk), .rstN(rstN), .srcAddr(srcAddr), .grant(grant), .strobe(strobe),
    .blockMatch(blockMatch), .favorReload(favorReload), .grantAddr(grantAddr)
  );
endmodule

// File: tb/l2arb_top_bench.sv
`timescale 1ns/1ps
module l2arb_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] v = '0;
  logic [31:0] a [5];
  logic [4:0] grant;
  logic [31:0] grantAddr;

  always #5 clk = ~clk;

  l2arb_top u_l2arb_top (
    .clk(clk), .rstN(rstN),
    .snoopValid(v[0]), .snoopAddr(a[0]),
    .dReloadValid(v[1]), .dReloadAddr(a[1]),
    .castoutValid(v[2]), .castoutAddr(a[2]),
    .iFetchValid(v[3]), .iFetchAddr(a[3]),
    .iReloadValid(v[4]), .iReloadAddr(a[4]),
    .grant(grant), .grantAddr(grantAddr)
  );

  typedef struct {
    logic [4:0]  expGrant;
    logic [31:0] expAddr;
    string       tag;
  } item_t;

  item_t sbq[$];
  int total = 0;
  int bad = 0;
  logic modelFavor = 1'b0;
  bit done = 1'b0;

  function automatic logic [4:0] model(logic [4:0] vv, logic [31:0] ra, logic [31:0] ca, logic fav);
    if (vv[0]) return 5'b00001;
    if (vv[1] && vv[2] && (ra[31:5] == ca[31:5])) return 5'b00100;
    if (vv[1]) return 5'b00010;
    if (vv[2]) return 5'b00100;
    if (vv[3] && vv[4]) return fav ? 5'b10000 : 5'b01000;
    if (vv[3]) return 5'b01000;
    if (vv[4]) return 5'b10000;
    return 5'b00000;
  endfunction

  task automatic drive(input logic [4:0] vv, input logic [31:0] a0, input logic [31:0] a1,
                       input logic [31:0] a2, input logic [31:0] a3, input logic [31:0] a4,
                       input string tag);
    item_t it;
    @(negedge clk);
    v = vv; a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3; a[4] = a4;
    it.expGrant = model(vv, a1, a2, modelFavor);
    it.expAddr = 32'h0;
    for (int s = 0; s < 5; s++) if (it.expGrant[s]) it.expAddr = a[s];
    it.tag = tag;
    sbq.push_back(it);
    if (it.expGrant[3]) modelFavor = 1'b1;
    else if (it.expGrant[4]) modelFavor = 1'b0;
  endtask

  // Monitor: samples 2 ns after each falling edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        total++;
        if (grant !== it.expGrant) begin
          bad++;
          $display("FAIL %s grant actual=%b expected=%b", it.tag, grant, it.expGrant);
        end
        total++;
        if (grantAddr !== it.expAddr) begin
          bad++;
          $display("FAIL R8 (%s) grantAddr actual=%h expected=%h", it.tag, grantAddr, it.expAddr);
        end
      end
    end
  end

  initial begin
    for (int s = 0; s < 5; s++) a[s] = 32'h0;
    repeat (3) @(negedge clk);
    // Reset state: idle gives no grant (R7)
    #2;
    total++;
    if (grant !== 5'b0 || grantAddr !== 32'h0) begin
      bad++;
      $display("FAIL R7 reset grant actual=%b expected=%b", grant, 5'b0);
    end
    @(negedge clk);
    rstN = 1'b1;
    drive(5'b00000, 0, 0, 0, 0, 0, "R7 idle");
    drive(5'b11111, 32'hA000, 32'h1000, 32'h1004, 32'h2000, 32'h3000, "R1 snoop over all");
    drive(5'b00110, 0, 32'h1000, 32'h1020, 0, 0, "R2 reload over other-block castout");
    drive(5'b00110, 0, 32'h1000, 32'h101F, 0, 0, "R3 same-block castout first");
    drive(5'b00110, 0, 32'h1003, 32'h1010, 0, 0, "R3 offset bits ignored");
    drive(5'b00111, 32'hB000, 32'h1000, 32'h1000, 0, 0, "R1 snoop over conflict");
    drive(5'b00010, 0, 32'h1000, 32'h1000, 0, 0, "R2 invalid castout no effect");
    drive(5'b11100, 0, 0, 32'h4000, 32'h2000, 32'h3000, "R4 castout over instruction");
    drive(5'b11010, 0, 32'h5000, 0, 32'h2000, 32'h3000, "R5 reload over instruction");
    drive(5'b11000, 0, 0, 0, 32'h2000, 32'h3000, "R6 first contest to fetch");
    drive(5'b11000, 0, 0, 0, 32'h2040, 32'h3040, "R6 alternate to reload");
    drive(5'b11000, 0, 0, 0, 32'h2080, 32'h3080, "R6 alternate to fetch");
    drive(5'b11001, 32'hC000, 0, 0, 32'h2080, 32'h3080, "R6 snoop cycle keeps turn");
    drive(5'b00000, 0, 0, 0, 0, 0, "R6 idle keeps turn");
    drive(5'b11000, 0, 0, 0, 32'h20C0, 32'h30C0, "R6 turn still reload");
    drive(5'b10000, 0, 0, 0, 0, 32'h3100, "R5 lone instruction reload");
    drive(5'b01000, 0, 0, 0, 32'h2100, 0, "R5 lone fetch");
    drive(5'b11000, 0, 0, 0, 32'h2140, 32'h3140, "R6 after lone fetch");
    for (int i = 0; i < 300; i++) begin
      logic [4:0] rv;
      logic [31:0] r1, r2;
      rv = 5'($urandom);
      if ((i % 4) == 0) rv[0] = 1'b0;
      r1 = 32'h8000 + ((32'($urandom) % 3) << 5) + (32'($urandom) % 32);
      r2 = 32'h8000 + ((32'($urandom) % 3) << 5) + (32'($urandom) % 32);
      drive(rv, 32'($urandom), r1, r2, 32'($urandom), 32'($urandom), "R7 random mix");
    end
    drive(5'b00000, 0, 0, 0, 0, 0, "R7 final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule